// File: doc/BRIEF.md
# Serial Diagnostic Word Readout

This block reports eleven diagnostic flags to a host controller over a three-wire serial link: a select line, a serial clock and a shared data line. Whenever select is high, the block keeps reloading its shift register from the live flags. These flags are four per-channel load faults, four per-channel commanded switch states, a temperature warning, a thermal shutdown and a supply overvoltage. While select is high, the data line is not driven, so other devices can use it.

Pulling select low freezes the word and drives its first bit at once. Each falling edge of the serial clock then presents the next bit, so the host can take each bit on the following rising edge. After the eleventh bit has been consumed, the line stays at logic 1 until select returns high. Select and serial clock are asynchronous to the block. They are brought into a faster system clock through two-flop synchronizers, and their edges are found from the synchronized values.

Top module: `diag_serial_readout`

## Requirements
- R1: The serial frame is 11 bits. Bits 1 to 4 carry the load-fault flags of channels 1 to 4 in that order, and bits 5 to 8 carry the commanded states of channels 1 to 4 in that order. Bits 9, 10 and 11 are the warning, shutdown and overvoltage flags.
- R2: Bit 9 is 0 when the temperature warning input is 1. Bit 10 is 0 when the shutdown input is 1. Bit 11 equals the overvoltage input. Bits 1 to 8 equal their inputs.
- R3: While select is high, the register reloads on every system clock, so a frame carries the flag values present when select fell.
- R4: The output enable is 0 while select is high, and is 0 during reset.
- R5: The first frame bit is on the data line as soon as the output enable rises, before any serial-clock falling edge.
- R6: Each serial-clock falling edge while selected advances the line by exactly one bit. Rising edges do not change the line.
- R7: Once all 11 bits have been advanced past, the line stays at logic 1 for any further falling edges until select goes high.
- R8: Raising select in the middle of a frame abandons it. The next frame starts again at bit 1 with fresh flags.
- R9: The output enable follows a change on select within 2 system clocks, and the data line changes within 3 system clocks of a serial-clock falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_i | input | 1 | Asynchronous select, active low |
| sclk_i | input | 1 | Asynchronous serial clock from the host |
| load_fault_i | input | 4 | Load-fault flag per channel, index 0 is channel 1 |
| sw_cmd_i | input | 4 | Commanded switch state per channel, index 0 is channel 1 |
| temp_warn_i | input | 1 | Over-temperature warning, active high |
| therm_shdn_i | input | 1 | Thermal shutdown, active high |
| overvolt_i | input | 1 | Supply overvoltage, active high |
| dout_o | output | 1 | Serial data value |
| dout_oe_o | output | 1 | Drive enable for the shared data line; high-Z when 0 |

## Verification
The output enable is due two system clocks after select changes. A new bit is due three system clocks after a serial-clock falling edge: two of these come from the synchronizer and one from the shift register. The bench keeps every serial-clock phase eight system clocks long. It samples the data line on the sixth system clock after each edge, which is after the latest due time and before the next edge. The bench drives and samples on the falling system-clock edge. Expected bits come from a bench function that builds the frame from the requirement ordering and polarity.

// File: rtl/diag_ser_pkg.sv
// Package: shared sizes of the diagnostic readout.
// Assumes the frame is two per-channel groups plus three device-wide flags.
package diag_ser_pkg;
    localparam int DIAG_CH = 4;
    localparam int DIAG_W  = 2 * DIAG_CH + 3;
    localparam int CNT_W   = $clog2(DIAG_W + 1);
endpackage

// File: rtl/diag_sync.sv
// Module: multi-stage synchronizer for one asynchronous level.
// Assumes the input is slow compared with clk; the reset value is the idle level.
module diag_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/diag_fall_det.sv
// Module: falling-edge detector on an already synchronized level.
// Assumes the input is in the clk domain; the pulse lasts one clk cycle.
module diag_fall_det #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic fall_o
);
    logic prev_q;

    // Remember the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= level_i;
        end
    end

    assign fall_o = prev_q & ~level_i;
endmodule

// File: rtl/diag_shifter.sv
// Module: parallel-load, MSB-first shift register with a frame bit counter.
// Assumes load and shift never act together; ones fill the vacated bits.
module diag_shifter
    import diag_ser_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic [DIAG_W-1:0] word_i,
    output logic             msb_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIAG_W);

    logic [DIAG_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              done;

    assign done = (cnt_q == LAST);

    // Reload while loading, otherwise advance one bit per shift request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '1;
        end else if (load_i) begin
            shreg_q <= word_i;
        end else if (shift_i && !done) begin
            shreg_q <= {shreg_q[DIAG_W-2:0], 1'b1};
        end
    end

    // Count bits advanced in this frame; clear while loading.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= '0;
        end else if (shift_i && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign msb_o = shreg_q[DIAG_W-1];
    assign cnt_o = cnt_q;
endmodule

// File: rtl/diag_serial_readout.sv
// Module: top of the serial diagnostic readout.
// Assumes clk is several times faster than sclk_i; select is active low.
module diag_serial_readout
    import diag_ser_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_i,
    input  logic               sclk_i,
    input  logic [DIAG_CH-1:0] load_fault_i,
    input  logic [DIAG_CH-1:0] sw_cmd_i,
    input  logic               temp_warn_i,
    input  logic               therm_shdn_i,
    input  logic               overvolt_i,
    output logic               dout_o,
    output logic               dout_oe_o
);
    logic              sel_s;
    logic              sclk_s;
    logic              sclk_fall;
    logic [DIAG_W-1:0] word;
    logic [CNT_W-1:0]  bit_cnt;

    diag_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel_sync (
        .clk(clk), .rst_n(rst_n), .async_i(sel_i), .sync_o(sel_s)
    );

    diag_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .async_i(sclk_i), .sync_o(sclk_s)
    );

    diag_fall_det #(.RST_VAL(1'b1)) u_sclk_fall (
        .clk(clk), .rst_n(rst_n), .level_i(sclk_s), .fall_o(sclk_fall)
    );

    // Place the per-channel flags: channel 1 leaves first in each group.
    for (genvar ch = 0; ch < DIAG_CH; ch++) begin : g_chan
        assign word[DIAG_W-1-ch]         = load_fault_i[ch];
        assign word[DIAG_W-1-DIAG_CH-ch] = sw_cmd_i[ch];
    end
    assign word[2] = ~temp_warn_i;
    assign word[1] = ~therm_shdn_i;
    assign word[0] = overvolt_i;

    diag_shifter u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sel_s),
        .shift_i (sclk_fall & ~sel_s),
        .word_i  (word),
        .msb_o   (dout_o),
        .cnt_o   (bit_cnt)
    );

    assign dout_oe_o = rst_n & ~sel_s;
endmodule

// File: rtl/diag_serial_readout_chk.sv
// Module: assertion checker bound to the readout top.
// Assumes it sees the top ports plus the falling-edge pulse and the bit counter.
module diag_serial_readout_chk
    import diag_ser_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [DIAG_CH-1:0] load_fault_i,
    input logic               dout_o,
    input logic               dout_oe_o,
    input logic               sclk_fall,
    input logic [CNT_W-1:0]   bit_cnt
);
    // R5 / R1: the first bit is channel-1 load fault when the line is enabled.
    p_first_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe_o) |-> dout_o == $past(load_fault_i[0]));

    // R6: without a falling edge, an enabled line holds its value.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe_o && !sclk_fall) |=> (!dout_oe_o || $stable(dout_o)));

    // R7: after the full frame the line is at logic 1.
    p_trail_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe_o && bit_cnt == CNT_W'(DIAG_W)) |-> dout_o);

    // R7: the bit counter never passes the frame length.
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(DIAG_W));

    // R8: a deselected interval restarts the frame count.
    p_cnt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe_o |=> bit_cnt == '0);
endmodule

bind diag_serial_readout diag_serial_readout_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_fault_i (load_fault_i),
    .dout_o       (dout_o),
    .dout_oe_o    (dout_oe_o),
    .sclk_fall    (sclk_fall),
    .bit_cnt      (bit_cnt)
);

// File: tb/diag_serial_readout_tb_top.sv
module diag_serial_readout_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b1;
    logic       sclk = 1'b1;
    logic [3:0] lf = '0;
    logic [3:0] sw = '0;
    logic       warn = 1'b0;
    logic       shdn = 1'b0;
    logic       ovv = 1'b0;
    logic       dout;
    logic       oe;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    diag_serial_readout dut_i (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_i(sclk),
        .load_fault_i(lf), .sw_cmd_i(sw), .temp_warn_i(warn),
        .therm_shdn_i(shdn), .overvolt_i(ovv),
        .dout_o(dout), .dout_oe_o(oe)
    );

    // Stimulus packing: [3:0] load faults, [7:4] commands, 8 warn, 9 shdn, 10 ovv.
    localparam int NV = 6;
    localparam logic [10:0] VEC [NV] = '{
        11'b000_0000_0000,
        11'b111_1111_1111,
        11'b001_1010_0101,
        11'b010_0101_1010,
        11'b100_0001_1000,
        11'b011_1000_0001
    };

    // Expected frame bit k (0-based) from the R1/R2 ordering and polarity.
    function automatic logic exp_bit(input logic [10:0] v, input int k);
        if (k < 4)       return v[k];
        else if (k < 8)  return v[k];
        else if (k == 8) return ~v[8];
        else if (k == 9) return ~v[9];
        else             return v[10];
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic apply(input logic [10:0] v);
        lf = v[3:0]; sw = v[7:4]; warn = v[8]; shdn = v[9]; ovv = v[10];
    endtask

    // One serial clock period: fall, sample, rise, sample for stability.
    task automatic sclk_cycle(input string req, input logic exp);
        sclk = 1'b0;
        wait_clk(6);
        check(req, dout, exp);
        wait_clk(2);
        sclk = 1'b1;
        wait_clk(6);
        check("R6 rising edge leaves line", dout, exp);
        wait_clk(2);
    endtask

    task automatic select_low(input logic [10:0] v);
        sel = 1'b0;
        wait_clk(1);
        check("R9 enable not before 2 clocks", oe, 1'b0);
        wait_clk(1);
        check("R9 enable after 2 clocks", oe, 1'b1);
        check("R5 first bit at enable", dout, exp_bit(v, 0));
        wait_clk(4);
    endtask

    bit finished = 0;

    initial begin
        wait_clk(3);
        check("R4 enable low in reset", oe, 1'b0);
        rst_n = 1'b1;
        wait_clk(4);
        check("R4 enable low when deselected", oe, 1'b0);

        // Table walk: full frames plus trailing ones (R1 R2 R3 R6 R7).
        for (int v = 0; v < NV; v++) begin
            apply(~VEC[v]);
            wait_clk(4);
            apply(VEC[v]);
            wait_clk(4);
            select_low(VEC[v]);
            for (int k = 1; k < 11; k++) sclk_cycle("R1 R2 frame bit", exp_bit(VEC[v], k));
            sclk_cycle("R7 trailing one", 1'b1);
            sclk_cycle("R7 trailing one held", 1'b1);
            sel = 1'b1;
            wait_clk(2);
            check("R4 enable drops after select high", oe, 1'b0);
            wait_clk(4);
        end

        // R4: serial clock toggling while deselected keeps line undriven.
        apply(VEC[2]);
        for (int i = 0; i < 3; i++) begin
            sclk = 1'b0; wait_clk(6); check("R4 no drive while deselected", oe, 1'b0);
            sclk = 1'b1; wait_clk(6);
        end
        // R3: frame still starts at bit 1 of the latest flags.
        select_low(VEC[2]);
        sclk_cycle("R3 second bit after idle toggles", exp_bit(VEC[2], 1));

        // R8: abort after a few bits, new flags, restart from bit 1.
        sclk_cycle("R8 pre-abort bit", exp_bit(VEC[2], 2));
        sel = 1'b1;
        apply(VEC[3]);
        wait_clk(8);
        select_low(VEC[3]);
        for (int k = 1; k < 11; k++) sclk_cycle("R8 restarted frame bit", exp_bit(VEC[3], k));
        sclk_cycle("R8 R7 trailing one after restart", 1'b1);

        // R9: bit change due exactly 3 clocks after a falling edge.
        sel = 1'b1;
        apply(VEC[2]);
        wait_clk(8);
        select_low(VEC[2]);
        sclk = 1'b0;
        wait_clk(2);
        check("R9 bit not before 3 clocks", dout, exp_bit(VEC[2], 0));
        wait_clk(1);
        check("R9 bit after 3 clocks", dout, exp_bit(VEC[2], 1));
        sclk = 1'b1;
        wait_clk(8);
        sel = 1'b1;
        wait_clk(4);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        wait_clk(100000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule